// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block lets a host read a fixed set of configuration items, each a byte string stored on chip and addressed by a 16-bit key. The host first writes a key to a selector register. It then pulls the item's bytes out in order through a data register, taking 1 to 8 bytes per read. A cursor inside the block remembers the current position in the selected item. Every selector write, valid or not, moves that cursor back to the start.

A wide read packs the item bytes with the earliest byte in the most significant lane of the requested width. If the item runs out partway through a read, the remaining low lanes are filled with zeros. Reads against an invalid key, an empty item or a finished item return zeros and leave the cursor where it is.

Two register layouts are available through a parameter:
- A split layout has a selector at offset 0 and a data window at offset 8.
- A combined layout uses a single address. There, byte accesses go to the data register and 16-bit writes go to the selector.

The host bus is a plain request/response bus with one cycle of read latency.

Top module: `cfg_item_reader`

## Requirements
- R1: After reset the selected key is 0 and the cursor is 0. Key 0 is the signature item, whose four bytes are 0x51, 0x45, 0x4D, 0x55 in that order. A first 4-byte read therefore returns 0x51454D55.
- R2: A selector write loads the key from wdata bits 15:0 and sets the cursor to 0, whether or not the key is valid.
- R3: Key bit 14 picks the bank (0 = common, 1 = architecture-local). Bits 13:0 are the entry index, and an index at or above ENTRY_COUNT (default 8) makes the selection invalid. Bit 15 has no effect.
- R4: The item contents are as follows. Bank 0, index 0 is the 4-byte signature. Bank 0, index i>0 holds 3*i bytes. Bank 1, index i holds 2*i bytes, so bank 1 index 0 is empty. The byte at position p of any item other than the signature is (16*(i mod 16) + p + 0x21 + 0x80*bank) mod 256.
- R5: A data read of N bytes (1..8) returns the item bytes from the cursor onward. The first byte sits in rdata[8N-1:8N-8], the next one below it, and rdata above bit 8N-1 is zero. The cursor advances by N.
- R6: If the item ends within an N-byte read, the lanes past the end read as zero and the cursor stops at the item length.
- R7: A data read returns zero and leaves the cursor unchanged in three cases: the selection is invalid, the item is empty, or the cursor is already at the item length.
- R8: In the split layout the selector is at address 0 and accepts only 2-byte writes. Data accesses are accepted only at address 8 with a size of 1..8. Any other read is rejected and returns zero. Any other access changes neither the key nor the cursor.
- R9: In the combined layout, at address 0, a 1-byte read is a data read and a 2-byte write is a selector write. A 2-byte read, or any other size, or any other address, is rejected with no side effect, and a rejected read returns zero.
- R10: Writes to the data register are accepted and ignored. The key and the cursor stay unchanged.
- R11: Every read request, accepted or rejected, produces exactly one response: rvalid is high in the cycle after the request, with rdata valid alongside it. Writes produce no response. rvalid and rdata are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (4) | Byte address within the block |
| size_i | input | 4 | Access size in bytes |
| wdata_i | input | 16 | Write data; the selector key on selector writes |
| rvalid_o | output | 1 | Read response valid, one cycle after a read request |
| rdata_o | output | 64 | Read response data |

## Verification
The bench goes after reads that straddle the end of an item. A design that padded on the wrong side, or let the cursor run past the length, would return shifted bytes, or non-zero data on the following read. It reselects a key in the middle of an item and reads the same bytes again. It also selects invalid and empty items, where a design that skipped the index check would leak bytes from an entry that does not exist.

Rejected and ignored accesses are each followed by a read that continues from the expected cursor. This exposes a decoder that lets a wrong-size selector write or a data write through. Back-to-back reads on both layouts check that each request gets exactly one response in the right cycle.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;

  localparam int unsigned KEY_W    = 16;
  localparam int unsigned IDX_W    = 14;
  localparam int unsigned BANK_BIT = 14;
  localparam int unsigned LEN_W    = 32;

  typedef struct packed {
    logic sel_wr;
    logic data_rd;
    logic data_wr;
    logic rej_rd;
  } acc_t;

  function automatic logic [LEN_W-1:0] item_len(input logic bank,
                                                input logic [IDX_W-1:0] idx);
    logic [LEN_W-1:0] wide_idx;
    wide_idx = {{(LEN_W-IDX_W){1'b0}}, idx};
    if (!bank && idx == '0) begin
      return 32'd4;
    end else if (!bank) begin
      return wide_idx * 32'd3;
    end else begin
      return wide_idx * 32'd2;
    end
  endfunction

  function automatic logic [7:0] item_byte(input logic bank,
                                           input logic [IDX_W-1:0] idx,
                                           input logic [LEN_W-1:0] pos);
    logic [7:0] b;
    if (!bank && idx == '0) begin
      case (pos)
        32'd0:   b = 8'h51;
        32'd1:   b = 8'h45;
        32'd2:   b = 8'h4D;
        default: b = 8'h55;
      endcase
    end else begin
      b = {idx[3:0], 4'h0} + pos[7:0] + 8'h21 + {bank, 7'h00};
    end
    return b;
  endfunction

endpackage

// File: rtl/cfgrd_item_rom.sv
module cfgrd_item_rom
  import cfgrd_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic                         bank_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [LEN_W-1:0]             base_i,
  output logic [LEN_W-1:0]             len_o,
  output logic [LANES-1:0][7:0]        lane_byte_o
);

  assign len_o = item_len(bank_i, idx_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_byte_o[g] = item_byte(bank_i, idx_i, base_i + LEN_W'(g));
  end

endmodule

// File: rtl/cfgrd_decode.sv
module cfgrd_decode
  import cfgrd_pkg::*;
#(
  parameter bit          COMBINED  = 1'b0,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned SIZE_W    = 4,
  parameter int unsigned MAX_BYTES = 8,
  parameter int unsigned SEL_ADDR  = 0,
  parameter int unsigned DATA_ADDR = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output acc_t              acc_o
);

  localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(SEL_ADDR);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);
  localparam logic [SIZE_W-1:0] MAX_SZ = SIZE_W'(MAX_BYTES);

  logic size_ok;
  assign size_ok = (size_i != '0) && (size_i <= MAX_SZ);

  if (COMBINED) begin : g_comb
    logic hit0;
    assign hit0 = req_i && (addr_i == SEL_A);
    always_comb begin
      acc_o         = '0;
      acc_o.data_rd = hit0 && !we_i && (size_i == SIZE_W'(1));
      acc_o.data_wr = hit0 &&  we_i && (size_i == SIZE_W'(1));
      acc_o.sel_wr  = hit0 &&  we_i && (size_i == SIZE_W'(2));
      acc_o.rej_rd  = req_i && !we_i && !acc_o.data_rd;
    end
  end else begin : g_split
    logic dhit;
    assign dhit = req_i && (addr_i == DATA_A) && size_ok;
    always_comb begin
      acc_o         = '0;
      acc_o.sel_wr  = req_i && we_i && (addr_i == SEL_A) && (size_i == SIZE_W'(2));
      acc_o.data_rd = dhit && !we_i;
      acc_o.data_wr = dhit &&  we_i;
      acc_o.rej_rd  = req_i && !we_i && !dhit;
    end
  end

  AST_SEL_IS_HALFWORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o.sel_wr |-> (we_i && size_i == SIZE_W'(2))); // R8
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_o.sel_wr, acc_o.data_rd, acc_o.data_wr, acc_o.rej_rd})); // R9
  AST_READ_CLASSIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i) |-> (acc_o.data_rd || acc_o.rej_rd)); // R11

endmodule

// File: rtl/cfgrd_cursor.sv
module cfgrd_cursor
  import cfgrd_pkg::*;
#(
  parameter int unsigned ENTRY_COUNT = 8,
  parameter int unsigned MAX_BYTES   = 8,
  parameter int unsigned SIZE_W      = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  acc_t                       acc_i,
  input  logic [SIZE_W-1:0]          size_i,
  input  logic [KEY_W-1:0]           wdata_i,
  output logic                       rvalid_o,
  output logic [8*MAX_BYTES-1:0]     rdata_o
);

  localparam int unsigned DATA_W = 8 * MAX_BYTES;

  logic [KEY_W-1:0]           key_q, key_d;
  logic [LEN_W-1:0]           ofs_q, ofs_d;
  logic [DATA_W-1:0]          rdata_q, rdata_d;
  logic                       rvalid_q, rvalid_d;
  logic                       key_en, ofs_en, rdata_en;

  logic                       key_valid;
  logic [LEN_W-1:0]           item_len_w;
  logic [MAX_BYTES-1:0][7:0]  lane_byte;
  logic                       has_data;
  logic [DATA_W-1:0]          packed_w;
  logic [LEN_W:0]             ofs_sum;

  cfgrd_item_rom #(.LANES(MAX_BYTES)) u_rom (
    .bank_i      (key_q[BANK_BIT]),
    .idx_i       (key_q[IDX_W-1:0]),
    .base_i      (ofs_q),
    .len_o       (item_len_w),
    .lane_byte_o (lane_byte)
  );

  assign key_valid = ({{(LEN_W-IDX_W){1'b0}}, key_q[IDX_W-1:0]} < LEN_W'(ENTRY_COUNT));
  assign has_data  = key_valid && (ofs_q < item_len_w);

  always_comb begin
    packed_w = '0;
    for (int i = 0; i < MAX_BYTES; i++) begin
      if ((i < int'(size_i)) && has_data && ((ofs_q + LEN_W'(i)) < item_len_w)) begin
        packed_w = packed_w |
                   (DATA_W'(lane_byte[i]) << (8 * (int'(size_i) - 1 - i)));
      end
    end
  end

  assign ofs_sum = {1'b0, ofs_q} + {{(LEN_W+1-SIZE_W){1'b0}}, size_i};

  always_comb begin
    key_d    = wdata_i;
    key_en   = acc_i.sel_wr;
    ofs_en   = acc_i.sel_wr || (acc_i.data_rd && has_data);
    if (acc_i.sel_wr) begin
      ofs_d = '0;
    end else if (ofs_sum > {1'b0, item_len_w}) begin
      ofs_d = item_len_w;
    end else begin
      ofs_d = ofs_sum[LEN_W-1:0];
    end
    rdata_en = acc_i.data_rd || acc_i.rej_rd;
    rdata_d  = acc_i.data_rd ? packed_w : '0;
    rvalid_d = acc_i.data_rd || acc_i.rej_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q    <= '0;
      ofs_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (key_en) begin
        key_q <= key_d;
      end
      if (ofs_en) begin
        ofs_q <= ofs_d;
      end
      if (rdata_en) begin
        rdata_q <= rdata_d;
      end
      rvalid_q <= rvalid_d;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

  AST_SEL_CLEARS_CURSOR: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i.sel_wr |=> (ofs_q == '0)); // R2
  AST_CURSOR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (ofs_q <= item_len_w)); // R6
  AST_INVALID_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i.data_rd && !key_valid) |=> (rdata_o == '0)); // R7
  AST_DATA_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i.data_wr |=> ($stable(ofs_q) && $stable(key_q))); // R10
  AST_KEY_ONLY_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_i.sel_wr |=> $stable(key_q)); // R8
  AST_READ_GETS_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i.data_rd || acc_i.rej_rd) |=> rvalid_o); // R11
  AST_WRITE_NO_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i.sel_wr || acc_i.data_wr) |=> !rvalid_o); // R11

endmodule

// File: rtl/cfg_item_reader.sv
module cfg_item_reader
  import cfgrd_pkg::*;
#(
  parameter bit          COMBINED    = 1'b0,
  parameter int unsigned ENTRY_COUNT = 8,
  parameter int unsigned MAX_BYTES   = 8,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SEL_ADDR    = 0,
  parameter int unsigned DATA_ADDR   = 8,
  localparam int unsigned SIZE_W     = $clog2(MAX_BYTES + 1),
  localparam int unsigned DATA_W     = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [KEY_W-1:0]  wdata_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);

  acc_t acc;

  cfgrd_decode #(
    .COMBINED  (COMBINED),
    .ADDR_W    (ADDR_W),
    .SIZE_W    (SIZE_W),
    .MAX_BYTES (MAX_BYTES),
    .SEL_ADDR  (SEL_ADDR),
    .DATA_ADDR (DATA_ADDR)
  ) u_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .size_i (size_i),
    .acc_o  (acc)
  );

  cfgrd_cursor #(
    .ENTRY_COUNT (ENTRY_COUNT),
    .MAX_BYTES   (MAX_BYTES),
    .SIZE_W      (SIZE_W)
  ) u_cursor (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_i    (acc),
    .size_i   (size_i),
    .wdata_i  (wdata_i),
    .rvalid_o (rvalid_o),
    .rdata_o  (rdata_o)
  );

endmodule

// File: tb/test_cfg_item_reader.sv
module test_cfg_item_reader;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        a_req, a_we, b_req, b_we;
  logic [3:0]  a_addr, a_size, b_addr, b_size;
  logic [15:0] a_wdata, b_wdata;
  logic        a_rvalid, b_rvalid;
  logic [63:0] a_rdata, b_rdata;

  cfg_item_reader #(.COMBINED(1'b0)) i_cfg_item_reader (
    .clk(clk), .rst_n(rst_n), .req_i(a_req), .we_i(a_we), .addr_i(a_addr),
    .size_i(a_size), .wdata_i(a_wdata), .rvalid_o(a_rvalid), .rdata_o(a_rdata));

  cfg_item_reader #(.COMBINED(1'b1)) i_cfg_item_reader_comb (
    .clk(clk), .rst_n(rst_n), .req_i(b_req), .we_i(b_we), .addr_i(b_addr),
    .size_i(b_size), .wdata_i(b_wdata), .rvalid_o(b_rvalid), .rdata_o(b_rdata));

  int n_cmp = 0;
  int n_bad = 0;

  logic [63:0] exp_q0[$], exp_q1[$];
  string       tag_q0[$], tag_q1[$];

  logic [15:0] mkey[2];
  int unsigned mofs[2];

  function automatic void check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endfunction

  function automatic int unsigned ref_len(logic bank, int unsigned idx);
    if (!bank && idx == 0) return 4;
    return bank ? 2 * idx : 3 * idx;
  endfunction

  function automatic logic [7:0] ref_byte(logic bank, int unsigned idx, int unsigned p);
    logic [7:0] sig [4];
    sig[0] = 8'h51; sig[1] = 8'h45; sig[2] = 8'h4D; sig[3] = 8'h55;
    if (!bank && idx == 0) return sig[p];
    return 8'((16 * (idx % 16) + p + 32'h21 + (bank ? 32'h80 : 32'h0)) % 256);
  endfunction

  function automatic logic [63:0] ref_read(int inst, int n);
    logic [63:0] v;
    logic bank;
    int unsigned idx, len;
    bank = mkey[inst][14];
    idx  = int'(mkey[inst][13:0]);
    v = '0;
    if (idx >= 8) return '0;
    len = ref_len(bank, idx);
    if (mofs[inst] >= len) return '0;
    for (int i = 0; i < n; i++) begin
      v = v << 8;
      if (mofs[inst] < len) begin
        v[7:0] = ref_byte(bank, idx, mofs[inst]);
        mofs[inst]++;
      end
    end
    return v;
  endfunction

  task automatic xfer(int inst, bit w, logic [3:0] a, int sz, logic [15:0] wd, string tag);
    logic [63:0] e;
    bit rd;
    @(negedge clk);
    if (inst == 0) begin
      a_req = 1'b1; a_we = w; a_addr = a; a_size = 4'(sz); a_wdata = wd;
    end else begin
      b_req = 1'b1; b_we = w; b_addr = a; b_size = 4'(sz); b_wdata = wd;
    end
    rd = !w;
    e  = '0;
    if (inst == 0) begin
      if (w && a == 4'd0 && sz == 2) begin
        mkey[0] = wd; mofs[0] = 0;
      end else if (!w && a == 4'd8 && sz >= 1 && sz <= 8) begin
        e = ref_read(0, sz);
      end
    end else begin
      if (w && a == 4'd0 && sz == 2) begin
        mkey[1] = wd; mofs[1] = 0;
      end else if (!w && a == 4'd0 && sz == 1) begin
        e = ref_read(1, 1);
      end
    end
    if (rd) begin
      if (inst == 0) begin exp_q0.push_back(e); tag_q0.push_back(tag); end
      else begin exp_q1.push_back(e); tag_q1.push_back(tag); end
    end
    @(posedge clk);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    a_req = 1'b0; b_req = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic rd_a(int sz, string tag); xfer(0, 1'b0, 4'd8, sz, 16'h0, tag); endtask
  task automatic sel_a(logic [15:0] k, string tag); xfer(0, 1'b1, 4'd0, 2, k, tag); endtask

  always @(negedge clk) begin
    if (rst_n && a_rvalid) begin
      if (exp_q0.size() == 0) check("R11 unexpected response split", a_rdata, 64'hX);
      else check(tag_q0.pop_front(), a_rdata, exp_q0.pop_front());
    end
    if (rst_n && b_rvalid) begin
      if (exp_q1.size() == 0) check("R11 unexpected response combined", b_rdata, 64'hX);
      else check(tag_q1.pop_front(), b_rdata, exp_q1.pop_front());
    end
  end

  bit finished = 1'b0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    a_req = 0; a_we = 0; a_addr = 0; a_size = 0; a_wdata = 0;
    b_req = 0; b_we = 0; b_addr = 0; b_size = 0; b_wdata = 0;
    mkey[0] = 16'h0; mkey[1] = 16'h0; mofs[0] = 0; mofs[1] = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset rvalid", {63'h0, a_rvalid}, 64'h0);
    check("R11 reset rdata", a_rdata, 64'h0);

    rd_a(4, "R1 signature after reset");
    rd_a(1, "R7 read past signature end");
    sel_a(16'h0000, "R2 reselect signature");
    rd_a(2, "R5 first half of signature");
    rd_a(2, "R5 second half of signature");
    rd_a(8, "R7 exhausted item");

    sel_a(16'h0003, "R3 bank0 index3");
    rd_a(8, "R5 eight byte read");
    rd_a(8, "R6 partial tail zero padded");
    rd_a(1, "R6 cursor stopped at length");

    sel_a(16'h4003, "R3 bank1 index3");
    rd_a(4, "R4 bank1 contents");
    rd_a(4, "R6 bank1 tail");

    sel_a(16'h4000, "R4 empty item");
    rd_a(4, "R7 empty item reads zero");
    sel_a(16'h0009, "R3 invalid index");
    rd_a(8, "R7 invalid selection reads zero");
    sel_a(16'h000F, "R3 invalid index high");
    rd_a(3, "R7 invalid selection reads zero again");

    sel_a(16'h8002, "R3 bit15 ignored");
    rd_a(3, "R3 bit15 ignored read");
    xfer(0, 1'b1, 4'd8, 1, 16'h00AA, "R10 data write");
    rd_a(3, "R10 cursor kept after data write");

    sel_a(16'h0005, "R2 select index5");
    xfer(0, 1'b0, 4'd0, 2, 16'h0, "R8 selector read rejected");
    xfer(0, 1'b1, 4'd0, 4, 16'h0001, "R8 wide selector write ignored");
    xfer(0, 1'b1, 4'd0, 1, 16'h0001, "R8 byte selector write ignored");
    xfer(0, 1'b0, 4'd9, 1, 16'h0, "R8 data offset 9 rejected");
    xfer(0, 1'b0, 4'd8, 0, 16'h0, "R8 size zero rejected");
    xfer(0, 1'b0, 4'd8, 9, 16'h0, "R8 size nine rejected");
    rd_a(5, "R8 cursor and key kept after rejects");
    rd_a(7, "R5 seven byte read");
    sel_a(16'h0005, "R2 reselect midway");
    rd_a(5, "R2 cursor back to start");
    rd_a(1, "R5 one byte read");
    rd_a(6, "R6 six byte read at tail");

    sel_a(16'h4007, "R3 bank1 index7");
    for (int k = 0; k < 5; k++) rd_a(3, "R11 back to back reads");
    idle(3);

    xfer(1, 1'b0, 4'd0, 1, 16'h0, "R9 combined signature byte0");
    xfer(1, 1'b0, 4'd0, 2, 16'h0, "R9 combined halfword read rejected");
    xfer(1, 1'b0, 4'd0, 1, 16'h0, "R9 combined signature byte1");
    xfer(1, 1'b1, 4'd0, 1, 16'h0055, "R10 combined data write ignored");
    xfer(1, 1'b0, 4'd0, 4, 16'h0, "R9 combined word read rejected");
    xfer(1, 1'b0, 4'd1, 1, 16'h0, "R9 combined other address rejected");
    xfer(1, 1'b1, 4'd1, 2, 16'h0002, "R9 combined select other address ignored");
    xfer(1, 1'b0, 4'd0, 1, 16'h0, "R9 combined signature byte2");
    xfer(1, 1'b1, 4'd0, 2, 16'h0001, "R9 combined selector write");
    for (int k = 0; k < 4; k++) xfer(1, 1'b0, 4'd0, 1, 16'h0, "R9 combined item bytes");
    idle(4);

    check("R11 all split responses arrived", 64'(exp_q0.size()), 64'h0);
    check("R11 all combined responses arrived", 64'(exp_q1.size()), 64'h0);
    finished = 1'b1;
    summary();
  end

endmodule